// File: doc/BRIEF.md
# Dual-Mode Data Link Receiver

This block takes a serial data-link bit stream, one bit per cycle in which the enable strobe is high, and receives it in one of two modes chosen by a configuration input. In message mode it finds HDLC frames, removes stuffed zeros and checks the frame check sequence. It writes each frame into one of two alternating buffers. When a frame is good, it reports the frame's byte length and which buffer now holds the newest frame. In bit-oriented mode it looks for repeated 16-bit codewords and counts how many times the same code arrives in a row. It compares that count against a programmed threshold.

Both modes signal completion through a single-cycle end-of-transfer pulse. A status readback word combines the newest-buffer pointer with a 7-bit count field, and the meaning of that field depends on the mode. A separate read port returns the stored frame bytes, so downstream logic can fetch a frame while the other buffer fills.

Top module: `dlink_rx`

## Requirements
- R1: After reset, `stat_rd` reads 0x00 in message mode, and `eot_irq` and `ovf_flag` are both 0.
- R2: In message mode the flag 01111110 opens and closes a frame. Data bytes arrive least significant bit first. A 0 that follows five consecutive 1s inside a frame is removed, so a data byte of 0xFF is stored intact.
- R3: A frame is accepted when all of the following hold: it closes on a byte boundary, it has at least 3 bytes, and the CRC-16 (reflected polynomial 0x8408, initial value 0xFFFF) run over the data and the FCS leaves the residue 0xF0B8. On acceptance, `stat_rd[7]` (the buffer pointer) toggles to the buffer just written, and `eot_irq` is high for exactly one cycle.
- R4: In message mode, `stat_rd[6:0]` reports the accepted frame's length in bytes. The length counts every byte from the first address byte through the two FCS bytes.
- R5: A frame with a wrong FCS produces no `eot_irq` and leaves `stat_rd` unchanged.
- R6: Seven or more consecutive 1s abort the current frame. Nothing is reported, and reception resumes at the next flag.
- R7: A frame that would exceed 127 bytes is discarded with no `eot_irq`, and `ovf_flag` is set. `ovf_flag` clears when the next frame is accepted.
- R8: `rd_data` returns the byte stored at address `rd_addr` in buffer `rd_bank`, one cycle after the request. Byte 0 is the first byte after the opening flag.
- R9: In bit-oriented mode a codeword is eight 1s, then a 0, then a 6-bit code sent most significant bit first, then a 0. When the same code has arrived `rep_limit` times in a row, `eot_irq` pulses once, `bos_code` shows the code, and `stat_rd[6:0]` reads `rep_limit`.
- R10: A codeword with a different code restarts the repetition count at 1.
- R11: With `rep_limit` equal to 0, codewords are received indefinitely and `eot_irq` never rises.
- R12: In bit-oriented mode a valid HDLC frame produces no `eot_irq` and leaves the buffer pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid line bit |
| bit_in | input | 1 | Line bit |
| mode_bos | input | 1 | 1 selects bit-oriented mode, 0 selects message mode |
| rep_limit | input | 7 | Repetition threshold used in bit-oriented mode |
| rd_bank | input | 1 | Buffer selected for reading |
| rd_addr | input | 7 | Byte address for reading |
| rd_data | output | 8 | Byte read from the selected buffer, one cycle later |
| stat_rd | output | 8 | Status word: bit 7 is the newest-buffer pointer, bits 6:0 are the count field |
| bos_code | output | 6 | Most recently received codeword code |
| eot_irq | output | 1 | End-of-transfer pulse |
| ovf_flag | output | 1 | Oversized frame was discarded |

## Verification
A wrong stuffing or byte-alignment state shows up at the closing flag of the same frame: the frame is either wrongly accepted or wrongly rejected. A wrong running CRC has the same effect. Because good, corrupted, aborted and oversized frames are mixed in one run, any of these errors also changes the pointer and length that later frames report. A wrong repetition count shows up as a missing or early end-of-transfer pulse at a known codeword. Buffer reads show a wrong write bank or address within one cycle of the request.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

    localparam int LEN_W   = 7;
    localparam int CODE_W  = 6;
    localparam int BYTE_W  = 8;
    localparam int CW_W    = 16;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam logic [15:0] CRC_POLY = 16'h8408;

    typedef struct packed {
        logic [2:0]        ones;
        logic              sync;
        logic [BYTE_W-1:0] sh;
        logic [2:0]        bcnt;
        logic              byte_stb;
        logic [BYTE_W-1:0] byte_val;
        logic              flag_stb;
        logic              flag_al;
        logic              abort_stb;
    } dfr_state_t;

    typedef struct packed {
        logic [CW_W-1:0]   sr;
        logic              have;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  run;
        logic              stb;
    } bos_state_t;

    typedef struct packed {
        logic              ptr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [15:0]       crc;
        logic              active;
        logic              ovf;
        logic              eot;
    } ctl_state_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
    import dlrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              flag_stb,
    output logic              flag_al,
    output logic              abort_stb
);

    dfr_state_t q, d;
    logic       do_shift;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        d           = q;
        d.byte_stb  = 1'b0;
        d.flag_stb  = 1'b0;
        d.flag_al   = 1'b0;
        d.abort_stb = 1'b0;
        do_shift    = 1'b0;
        shifted     = {bit_in, q.sh[BYTE_W-1:1]};
        if (bit_en) begin
            if (bit_in) begin
                if (q.ones == 3'd6) begin
                    d.abort_stb = q.sync;
                    d.sync      = 1'b0;
                    d.ones      = 3'd7;
                end else if (q.ones != 3'd7) begin
                    d.ones   = q.ones + 3'd1;
                    do_shift = 1'b1;
                end
            end else begin
                d.ones = 3'd0;
                if (q.ones == 3'd6) begin
                    d.flag_stb = 1'b1;
                    d.flag_al  = q.sync && (q.bcnt == 3'd7);
                    d.sync     = 1'b1;
                    d.bcnt     = 3'd0;
                end else if (q.ones != 3'd5 && q.ones != 3'd7) begin
                    do_shift = 1'b1;
                end
            end
        end
        if (do_shift && q.sync) begin
            d.sh = shifted;
            if (q.bcnt == 3'd7) begin
                d.byte_stb = 1'b1;
                d.byte_val = shifted;
                d.bcnt     = 3'd0;
            end else begin
                d.bcnt = q.bcnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_stb  = q.byte_stb;
    assign byte_val  = q.byte_val;
    assign flag_stb  = q.flag_stb;
    assign flag_al   = q.flag_al;
    assign abort_stb = q.abort_stb;

endmodule

// File: rtl/bos_detect.sv
module bos_detect
    import dlrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              match_stb,
    output logic [CODE_W-1:0] match_code,
    output logic [LEN_W-1:0]  run_len
);

    localparam logic [LEN_W-1:0] RUN_MAX = '1;

    bos_state_t q, d;
    logic [CW_W-1:0]   sr_n;
    logic [CODE_W-1:0] code_n;

    always_comb begin
        d      = q;
        d.stb  = 1'b0;
        sr_n   = {q.sr[CW_W-2:0], bit_in};
        code_n = sr_n[CODE_W:1];
        if (bit_en) begin
            if (sr_n[CW_W-1:CW_W-8] == 8'hFF && !sr_n[CW_W-9] && !sr_n[0]) begin
                d.sr   = '0;
                d.stb  = 1'b1;
                d.have = 1'b1;
                d.code = code_n;
                if (q.have && code_n == q.code)
                    d.run = (q.run == RUN_MAX) ? RUN_MAX : q.run + 1'b1;
                else
                    d.run = LEN_W'(1);
            end else begin
                d.sr = sr_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign match_stb  = q.stb;
    assign match_code = q.code;
    assign run_len    = q.run;

endmodule

// File: rtl/msg_buf.sv
module msg_buf #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank_rd [2];
    logic [DW-1:0] rd_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == 1'(g)) mem[wr_addr] <= wr_data;
        end
        assign bank_rd[g] = mem[rd_addr];
    end

    always_ff @(posedge clk) rd_q <= bank_rd[rd_bank];

    assign rd_data = rd_q;

endmodule

// File: rtl/dlink_rx.sv
module dlink_rx
    import dlrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              mode_bos,
    input  logic [LEN_W-1:0]  rep_limit,
    input  logic              rd_bank,
    input  logic [LEN_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [LEN_W:0]    stat_rd,
    output logic [CODE_W-1:0] bos_code,
    output logic              eot_irq,
    output logic              ovf_flag
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(3);

    logic              byte_stb, flag_stb, flag_al, abort_stb;
    logic [BYTE_W-1:0] byte_val;
    logic              bos_stb;
    logic [LEN_W-1:0]  bos_run;
    logic              wr_en;

    ctl_state_t q, d;

    hdlc_deframer u_dfr (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .byte_stb(byte_stb), .byte_val(byte_val),
        .flag_stb(flag_stb), .flag_al(flag_al), .abort_stb(abort_stb)
    );

    bos_detect u_bos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .match_stb(bos_stb), .match_code(bos_code), .run_len(bos_run)
    );

    msg_buf #(.AW(LEN_W), .DW(BYTE_W)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_bank(~q.ptr), .wr_addr(q.cnt),
        .wr_data(byte_val), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        d     = q;
        d.eot = 1'b0;
        wr_en = 1'b0;
        if (!mode_bos) begin
            if (abort_stb) d.active = 1'b0;
            if (byte_stb && q.active) begin
                if (q.cnt == LEN_MAX) begin
                    d.active = 1'b0;
                    d.ovf    = 1'b1;
                end else begin
                    wr_en = 1'b1;
                    d.cnt = q.cnt + 1'b1;
                    d.crc = crc16_byte(q.crc, byte_val);
                end
            end
            if (flag_stb) begin
                if (q.active && flag_al && q.cnt >= LEN_MIN && q.crc == CRC_GOOD) begin
                    d.ptr = ~q.ptr;
                    d.len = q.cnt;
                    d.eot = 1'b1;
                    d.ovf = 1'b0;
                end
                d.active = 1'b1;
                d.cnt    = '0;
                d.crc    = CRC_SEED;
            end
        end else begin
            d.active = 1'b0;
            if (bos_stb && rep_limit != '0 && bos_run == rep_limit) d.eot = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_rd  = {q.ptr, mode_bos ? rep_limit : q.len};
    assign eot_irq  = q.eot;
    assign ovf_flag = q.ovf;

endmodule

// File: rtl/dlink_rx_chk.sv
module dlink_rx_chk
    import dlrx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              bit_in,
    input logic              mode_bos,
    input logic [LEN_W-1:0]  rep_limit,
    input logic              rd_bank,
    input logic [LEN_W-1:0]  rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [LEN_W:0]    stat_rd,
    input logic [CODE_W-1:0] bos_code,
    input logic              eot_irq,
    input logic              ovf_flag
);

    // R3
    eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_irq |=> !eot_irq);

    // R3
    ptr_moves_with_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_rd[LEN_W]) |-> eot_irq);

    // R4
    len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_irq && !mode_bos && $stable(mode_bos)) |-> stat_rd[LEN_W-1:0] >= LEN_W'(3));

    // R7
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(!mode_bos));

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> eot_irq);

    // R11
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bos && $stable(mode_bos) && rep_limit == '0 && $stable(rep_limit)) |-> !eot_irq);

endmodule

bind dlink_rx dlink_rx_chk u_chk (.*);

// File: tb/dlink_rx_tb.sv
module dlink_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       mode_bos = 1'b0;
    logic [6:0] rep_limit = '0;
    logic       rd_bank = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] stat_rd;
    logic [5:0] bos_code;
    logic       eot_irq;
    logic       ovf_flag;

    always #5 clk = ~clk;

    dlink_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .mode_bos(mode_bos), .rep_limit(rep_limit), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_data(rd_data), .stat_rd(stat_rd),
        .bos_code(bos_code), .eot_irq(eot_irq), .ovf_flag(ovf_flag)
    );

    typedef struct {
        logic [7:0] stat;
        logic       ovf;
        logic       bos;
        logic [5:0] code;
    } exp_t;

    exp_t       exp_q[$];
    int         checks = 0;
    int         errors = 0;
    int         eot_seen = 0;
    int         ones_tx = 0;
    logic       exp_ptr = 1'b0;
    logic [7:0] frame_b [0:255];
    bit         done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && eot_irq) begin
            eot_seen++;
            if (exp_q.size() == 0) begin
                chk("R3 unexpected eot", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3/R4/R9 status at eot", {24'd0, stat_rd}, {24'd0, e.stat});
                chk("R7 ovf at eot", {31'd0, ovf_flag}, {31'd0, e.ovf});
                if (e.bos) chk("R9 code at eot", {26'd0, bos_code}, {26'd0, e.code});
            end
        end
    end

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_flag();
        send_raw(0);
        for (int i = 0; i < 6; i++) send_raw(1);
        send_raw(0);
        ones_tx = 0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            ones_tx++;
            if (ones_tx == 5) begin
                send_raw(0);
                ones_tx = 0;
            end
        end else begin
            ones_tx = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r;
        r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            r = r ^ {8'd0, frame_b[i]};
            for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

    task automatic send_frame(input int n, input int seed, input bit corrupt, input bit push);
        logic [15:0] fcs;
        for (int i = 0; i < n; i++) frame_b[i] = 8'(seed + i * 37);
        if (n > 1) frame_b[1] = 8'hFF;
        fcs = ~ref_crc(n);
        if (corrupt) fcs = fcs ^ 16'h0001;
        frame_b[n]     = fcs[7:0];
        frame_b[n + 1] = fcs[15:8];
        if (push) begin
            exp_t e;
            exp_ptr = ~exp_ptr;
            e.stat = {exp_ptr, 7'(n + 2)};
            e.ovf  = 1'b0;
            e.bos  = 1'b0;
            e.code = '0;
            exp_q.push_back(e);
        end
        send_flag();
        for (int i = 0; i < n + 2; i++) send_byte(frame_b[i]);
        send_flag();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_code(input logic [5:0] c);
        for (int i = 0; i < 8; i++) send_raw(1);
        send_raw(0);
        for (int i = 5; i >= 0; i--) send_raw(c[i]);
        send_raw(0);
    endtask

    task automatic push_bos(input logic [5:0] c);
        exp_t e;
        e.stat = {exp_ptr, rep_limit};
        e.ovf  = 1'b0;
        e.bos  = 1'b1;
        e.code = c;
        exp_q.push_back(e);
    endtask

    task automatic rd_chk(input logic bank, input int addr, input logic [7:0] exp);
        @(negedge clk);
        rd_bank = bank;
        rd_addr = 7'(addr);
        @(negedge clk);
        chk("R8 buffer read", {24'd0, rd_data}, {24'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 stat after reset", {24'd0, stat_rd}, 32'd0);
        chk("R1 eot after reset", {31'd0, eot_irq}, 32'd0);
        chk("R1 ovf after reset", {31'd0, ovf_flag}, 32'd0);

        // R3 R4 accepted frame, R2 stuffed 0xFF byte, R8 buffer contents
        send_frame(4, 8'h11, 0, 1);
        chk("R4 length of 4+2 byte frame", {24'd0, stat_rd}, {24'd0, 1'b1, 7'd6});
        for (int i = 0; i < 6; i++) rd_chk(1'b1, i, frame_b[i]);
        chk("R2 stuffed 0xFF byte kept", {24'd0, frame_b[1]}, 32'hFF);

        send_frame(10, 8'h5A, 0, 1);
        chk("R3 pointer toggled back", {31'd0, stat_rd[7]}, 32'd0);
        rd_chk(1'b0, 11, frame_b[11]);
        rd_chk(1'b0, 0, frame_b[0]);

        // R5 corrupted FCS
        base = eot_seen;
        send_frame(5, 8'h33, 1, 0);
        chk("R5 stat unchanged after bad FCS", {24'd0, stat_rd}, {24'd0, 1'b0, 7'd12});
        chk("R5 no eot after bad FCS", 32'(eot_seen), 32'(base));

        // R6 abort
        send_flag();
        send_byte(8'h01);
        send_byte(8'h02);
        send_byte(8'h03);
        for (int i = 0; i < 8; i++) send_raw(1);
        ones_tx = 0;
        repeat (4) @(negedge clk);
        chk("R6 stat unchanged after abort", {24'd0, stat_rd}, {24'd0, 1'b0, 7'd12});
        chk("R6 no eot after abort", 32'(eot_seen), 32'(base));
        send_frame(2, 8'h77, 0, 1);
        chk("R6 recovery frame length", {24'd0, stat_rd}, {24'd0, 1'b1, 7'd4});

        // R7 overflow
        send_frame(130, 8'h21, 0, 0);
        chk("R7 ovf set after long frame", {31'd0, ovf_flag}, 32'd1);
        chk("R7 stat unchanged after long frame", {24'd0, stat_rd}, {24'd0, 1'b1, 7'd4});
        send_frame(3, 8'h44, 0, 1);
        chk("R7 ovf cleared by good frame", {31'd0, ovf_flag}, 32'd0);

        // R9 R10 bit-oriented repetitions
        @(negedge clk);
        mode_bos  = 1'b1;
        rep_limit = 7'd3;
        @(negedge clk);
        chk("R9 count field shows threshold", {24'd0, stat_rd}, {24'd0, exp_ptr, 7'd3});
        base = eot_seen;
        send_code(6'h15);
        send_code(6'h15);
        send_code(6'h2A);
        send_code(6'h15);
        send_code(6'h15);
        repeat (4) @(negedge clk);
        chk("R10 restart prevents early eot", 32'(eot_seen), 32'(base));
        push_bos(6'h15);
        send_code(6'h15);
        repeat (4) @(negedge clk);
        chk("R9 eot after third repeat", 32'(eot_seen), 32'(base + 1));

        // R11 zero threshold
        rep_limit = 7'd0;
        base = eot_seen;
        for (int i = 0; i < 5; i++) send_code(6'h3F);
        repeat (4) @(negedge clk);
        chk("R11 no eot with zero threshold", 32'(eot_seen), 32'(base));
        chk("R11 code still tracked", {26'd0, bos_code}, 32'h3F);

        // R12 frames ignored in bit-oriented mode
        send_frame(4, 8'h66, 0, 0);
        chk("R12 no eot for frame in bit mode", 32'(eot_seen), 32'(base));
        chk("R12 pointer unchanged", {31'd0, stat_rd[7]}, {31'd0, exp_ptr});

        chk("R3 all expected eots seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule